// File: doc/BRIEF.md
# High-Speed Clock Lane Sequencer for a Serial Display Link Host

This block drives the clock lane of a serial display link transmitter and schedules packets onto the data lanes. A policy input chooses between two ways of running the high-speed clock. In the first, the clock is started once after reset and then runs for as long as the link is in use. In the second, the clock is started only when a high-speed packet is waiting, and it is stopped again after the burst. The per-packet choice between high-speed and low-power signalling is a separate input and does not depend on the clock policy.

Lane activity is reported as abstract line-state codes and flags rather than analog levels. The clock lane output carries one of LP-11, LP-01, LP-00 or HS. Each data lane has a stop flag and a high-speed-burst flag. The clock lane also has a stopped flag and a ready flag. The start-up timing (prepare and zero phases), the clock lead before a burst, the clock tail after a burst, and the trail before the lane returns to rest are all set from input ports in clock cycles. An initialization-complete flag rises once the lanes have settled in the state that the active policy expects.

Top module: `cls_clk_lane_ctrl`

## Requirements
- R1: During reset the clock lane code is LP-11 (2'b11), clk_stop is 1, clk_ready is 0, every data_stop bit is 1, every data_hs bit is 0, init_done is 0 and pkt_ready is 1.
- R2: A clock start follows a fixed order on clk_line. LP-11 (2'b11) is followed by exactly one cycle of LP-01 (2'b01). Then LP-00 (2'b00) is held for max(t_prepare,1) cycles. Then HS (2'b10) is held with clk_ready low for max(t_zero,1) cycles, after which clk_ready rises.
- R3: With the continuous policy in force (policy_tx_only = 0), the clock is started after reset, and once clk_ready is 1 it stays 1 with no return to LP-11 while that policy remains in force.
- R4: A high-speed packet (pkt_hs = 1) drives data_hs = 1 and data_stop = 0 on exactly the lanes of the mask latched at acceptance, for max(pkt_len,1) consecutive cycles. It starts only after clk_ready has been 1 for at least t_pre cycles (t_pre >= 1). When the clock was started for that packet, clk_ready has been 1 for exactly t_pre cycles.
- R5: With the transmit-only policy (policy_tx_only = 1), the clock stays ready for exactly t_post cycles (t_post >= 1) after the last burst cycle. clk_line then stays HS with clk_ready 0 for max(t_trail,1) cycles. The lane then rests at LP-11 with clk_stop = 1.
- R6: A low-power packet (pkt_hs = 0) drives data_stop = 0 and data_hs = 0 on the masked lanes for max(pkt_len,1) cycles and leaves the clock lane as it was. Under the continuous policy clk_ready stays 1. Under the transmit-only policy clk_stop stays 1.
- R7: clk_line is never LP-11 while any data_hs bit is 1, and clk_stop and clk_ready are never 1 together.
- R8: init_done becomes 1 once three conditions hold: the requested policy is in force, every lane enabled in lane_mask reports stop, and the clock is ready (continuous) or stopped (transmit-only). It then stays 1 until reset.
- R9: A change on policy_tx_only takes effect only at an edge where no packet is in progress. While a packet runs, the previous policy keeps controlling the clock lane.
- R10: A packet is accepted at an edge where pkt_valid and pkt_ready are both 1. pkt_ready is 0 from the next cycle until the packet has finished, and lane_mask is latched at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_tx_only | input | 1 | 0 = clock always on, 1 = clock only around high-speed bursts |
| lane_mask | input | NLANES | Enabled data lanes |
| pkt_valid | input | 1 | Packet request |
| pkt_hs | input | 1 | 1 = high-speed packet, 0 = low-power packet |
| pkt_len | input | LEN_W | Packet duration in cycles |
| pkt_ready | output | 1 | Sequencer can accept a packet |
| t_prepare | input | CNT_W | LP-00 cycles during clock start |
| t_zero | input | CNT_W | Leading HS-zero cycles |
| t_pre | input | CNT_W | Ready cycles required before a burst |
| t_post | input | CNT_W | Ready cycles kept after a burst |
| t_trail | input | CNT_W | Trail cycles before LP-11 |
| clk_line | output | 2 | Clock lane code: 11 LP-11, 01 LP-01, 00 LP-00, 10 HS |
| clk_ready | output | 1 | High-speed clock running and ready |
| clk_stop | output | 1 | Clock lane in stop state |
| data_hs | output | NLANES | Per-lane high-speed burst flag |
| data_stop | output | NLANES | Per-lane stop-state flag |
| init_done | output | 1 | Initialization handshake complete |

## Verification
The bench builds the block with its defaults: NLANES = 4, CNT_W = 8 and LEN_W = 8. It runs one phase with lane mask 1011 and timers 3/5/4/6/3 (prepare, zero, pre, post, trail), which keeps each phase of clock start and stop separately measurable. A second phase, entered through reset, uses mask 0110 and all timers at 1, which reaches the shortest case where each phase lasts a single cycle. The eight-bit widths let bursts of a few cycles and packets longer than any timer run in both policies, including a policy change during a low-power packet.

// File: rtl/cls_pkg.sv
package cls_pkg;

    typedef enum logic [1:0] {
        LINE_LP00 = 2'b00,
        LINE_LP01 = 2'b01,
        LINE_HS   = 2'b10,
        LINE_LP11 = 2'b11
    } line_t;

    typedef enum logic [2:0] {
        CK_STOP,
        CK_LP01,
        CK_LP00,
        CK_ZERO,
        CK_RUN,
        CK_TRAIL
    } ck_state_t;

    typedef enum logic [1:0] {
        PK_IDLE,
        PK_WAIT,
        PK_HS,
        PK_LP
    } pk_state_t;

endpackage

// File: rtl/cls_clk_fsm.sv
module cls_clk_fsm
    import cls_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             policy_req,
    input  logic             eng_busy,
    input  logic             hs_want,
    input  logic             burst,
    input  logic [CNT_W-1:0] t_prepare,
    input  logic [CNT_W-1:0] t_zero,
    input  logic [CNT_W-1:0] t_pre,
    input  logic [CNT_W-1:0] t_post,
    input  logic [CNT_W-1:0] t_trail,
    output logic [1:0]       clk_line,
    output logic             clk_ready,
    output logic             clk_stop,
    output logic             pol_active,
    output logic             pre_ok
);

    typedef struct packed {
        ck_state_t        st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hs_age;
        logic [CNT_W-1:0] idle_age;
        logic             pol;
    } ck_regs_t;

    ck_regs_t q, d;
    logic [CNT_W:0] cnt_w;
    line_t          line_code;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == {CNT_W{1'b1}}) ? v : v + 1'b1;
    endfunction

    always_comb begin
        d     = q;
        cnt_w = {1'b0, q.cnt} + 1'b1;
        // policy only moves at a stable clock state with no packet underway
        if (!eng_busy && (q.st == CK_STOP || q.st == CK_RUN))
            d.pol = policy_req;
        case (q.st)
            CK_STOP: begin
                if (!q.pol || hs_want)
                    d.st = CK_LP01;
            end
            CK_LP01: begin
                d.st  = CK_LP00;
                d.cnt = '0;
            end
            CK_LP00: begin
                if (cnt_w >= {1'b0, t_prepare}) begin
                    d.st  = CK_ZERO;
                    d.cnt = '0;
                end else begin
                    d.cnt = cnt_w[CNT_W-1:0];
                end
            end
            CK_ZERO: begin
                if (cnt_w >= {1'b0, t_zero}) begin
                    d.st       = CK_RUN;
                    d.cnt      = '0;
                    d.hs_age   = {{(CNT_W-1){1'b0}}, 1'b1};
                    d.idle_age = {{(CNT_W-1){1'b0}}, 1'b1};
                end else begin
                    d.cnt = cnt_w[CNT_W-1:0];
                end
            end
            CK_RUN: begin
                d.hs_age   = sat_inc(q.hs_age);
                d.idle_age = burst ? {{(CNT_W-1){1'b0}}, 1'b1} : sat_inc(q.idle_age);
                if (q.pol && !hs_want && q.idle_age >= t_post) begin
                    d.st  = CK_TRAIL;
                    d.cnt = '0;
                end
            end
            CK_TRAIL: begin
                if (cnt_w >= {1'b0, t_trail}) begin
                    d.st  = CK_STOP;
                    d.cnt = '0;
                end else begin
                    d.cnt = cnt_w[CNT_W-1:0];
                end
            end
            default: d.st = CK_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st       <= CK_STOP;
            q.cnt      <= '0;
            q.hs_age   <= '0;
            q.idle_age <= '0;
            q.pol      <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (q.st)
            CK_STOP:  line_code = LINE_LP11;
            CK_LP01:  line_code = LINE_LP01;
            CK_LP00:  line_code = LINE_LP00;
            default:  line_code = LINE_HS;
        endcase
    end

    assign clk_line   = line_code;
    assign clk_ready  = (q.st == CK_RUN);
    assign clk_stop   = (q.st == CK_STOP);
    assign pol_active = q.pol;
    assign pre_ok     = (q.hs_age >= t_pre);

    AST_LP01_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == CK_LP01) |-> ($past(q.st) == CK_STOP)); // R2

    AST_CONT_KEEPS_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == CK_RUN && !q.pol) |=> (q.st == CK_RUN)); // R3

    AST_PRE_MET: assert property (@(posedge clk) disable iff (!rst_n)
        (burst && !$past(burst)) |-> (q.hs_age >= t_pre)); // R4

    AST_POLICY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && $past(eng_busy)) |-> $stable(q.pol)); // R9

endmodule

// File: rtl/cls_pkt_eng.sv
module cls_pkt_eng
    import cls_pkg::*;
#(
    parameter int NLANES = 4,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic              pkt_hs,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic [NLANES-1:0] lane_mask,
    input  logic              clk_ready,
    input  logic              pre_ok,
    output logic              pkt_ready,
    output logic              busy,
    output logic              hs_want,
    output logic              burst,
    output logic              lane_act,
    output logic [NLANES-1:0] mask_out
);

    typedef struct packed {
        pk_state_t         st;
        logic [LEN_W-1:0]  cnt;
        logic [NLANES-1:0] mask;
    } pk_regs_t;

    pk_regs_t q, d;

    always_comb begin
        d = q;
        case (q.st)
            PK_IDLE: begin
                if (pkt_valid) begin
                    d.mask = lane_mask;
                    d.cnt  = (pkt_len == '0) ? '0 : pkt_len - 1'b1;
                    d.st   = pkt_hs ? PK_WAIT : PK_LP;
                end
            end
            PK_WAIT: begin
                if (clk_ready && pre_ok)
                    d.st = PK_HS;
            end
            PK_HS, PK_LP: begin
                if (q.cnt == '0)
                    d.st = PK_IDLE;
                else
                    d.cnt = q.cnt - 1'b1;
            end
            default: d.st = PK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= PK_IDLE;
            q.cnt  <= '0;
            q.mask <= '0;
        end else begin
            q <= d;
        end
    end

    assign pkt_ready = (q.st == PK_IDLE);
    assign busy      = (q.st != PK_IDLE);
    assign hs_want   = (q.st == PK_WAIT) || (q.st == PK_HS);
    assign burst     = (q.st == PK_HS);
    assign lane_act  = (q.st == PK_HS) || (q.st == PK_LP);
    assign mask_out  = q.mask;

    AST_BURST_NEEDS_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        burst |-> clk_ready); // R7

    AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready) |=> !pkt_ready); // R10

endmodule

// File: rtl/cls_lane_stat.sv
module cls_lane_stat #(
    parameter int NLANES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst,
    input  logic              lane_act,
    input  logic [NLANES-1:0] mask_q,
    input  logic [NLANES-1:0] lane_mask,
    input  logic              clk_ready,
    input  logic              clk_stop,
    input  logic              pol_active,
    input  logic              policy_req,
    output logic [NLANES-1:0] data_hs,
    output logic [NLANES-1:0] data_stop,
    output logic              init_done
);

    typedef struct packed {
        logic done;
    } st_regs_t;

    st_regs_t q, d;
    logic     lanes_quiet;
    logic     clock_settled;

    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        assign data_hs[i]   = burst & mask_q[i];
        assign data_stop[i] = ~(lane_act & mask_q[i]);
    end

    always_comb begin
        lanes_quiet   = &(data_stop | ~lane_mask);
        clock_settled = (pol_active == policy_req) &&
                        (pol_active ? clk_stop : clk_ready);
        d.done        = q.done | (lanes_quiet & clock_settled);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q.done <= 1'b0;
        else        q      <= d;
    end

    assign init_done = q.done;

    AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done); // R8

endmodule

// File: rtl/cls_clk_lane_ctrl.sv
module cls_clk_lane_ctrl
    import cls_pkg::*;
#(
    parameter int NLANES = 4,
    parameter int CNT_W  = 8,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              policy_tx_only,
    input  logic [NLANES-1:0] lane_mask,
    input  logic              pkt_valid,
    input  logic              pkt_hs,
    input  logic [LEN_W-1:0]  pkt_len,
    output logic              pkt_ready,
    input  logic [CNT_W-1:0]  t_prepare,
    input  logic [CNT_W-1:0]  t_zero,
    input  logic [CNT_W-1:0]  t_pre,
    input  logic [CNT_W-1:0]  t_post,
    input  logic [CNT_W-1:0]  t_trail,
    output logic [1:0]        clk_line,
    output logic              clk_ready,
    output logic              clk_stop,
    output logic [NLANES-1:0] data_hs,
    output logic [NLANES-1:0] data_stop,
    output logic              init_done
);

    logic              busy, hs_want, burst, lane_act, pol_active, pre_ok;
    logic [NLANES-1:0] mask_q;

    cls_pkt_eng #(.NLANES(NLANES), .LEN_W(LEN_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_valid (pkt_valid),
        .pkt_hs    (pkt_hs),
        .pkt_len   (pkt_len),
        .lane_mask (lane_mask),
        .clk_ready (clk_ready),
        .pre_ok    (pre_ok),
        .pkt_ready (pkt_ready),
        .busy      (busy),
        .hs_want   (hs_want),
        .burst     (burst),
        .lane_act  (lane_act),
        .mask_out  (mask_q)
    );

    cls_clk_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .policy_req (policy_tx_only),
        .eng_busy   (busy),
        .hs_want    (hs_want),
        .burst      (burst),
        .t_prepare  (t_prepare),
        .t_zero     (t_zero),
        .t_pre      (t_pre),
        .t_post     (t_post),
        .t_trail    (t_trail),
        .clk_line   (clk_line),
        .clk_ready  (clk_ready),
        .clk_stop   (clk_stop),
        .pol_active (pol_active),
        .pre_ok     (pre_ok)
    );

    cls_lane_stat #(.NLANES(NLANES)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .burst      (burst),
        .lane_act   (lane_act),
        .mask_q     (mask_q),
        .lane_mask  (lane_mask),
        .clk_ready  (clk_ready),
        .clk_stop   (clk_stop),
        .pol_active (pol_active),
        .policy_req (policy_tx_only),
        .data_hs    (data_hs),
        .data_stop  (data_stop),
        .init_done  (init_done)
    );

    AST_HS_NOT_LP11: assert property (@(posedge clk) disable iff (!rst_n)
        (|data_hs) |-> (clk_line != 2'b11)); // R7

endmodule

// File: tb/tb_cls_clk_lane_ctrl.sv
module tb_cls_clk_lane_ctrl;

    localparam int NL = 4;
    localparam int CW = 8;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          policy_tx_only = 1'b0;
    logic [NL-1:0] lane_mask = 4'b1011;
    logic          pkt_valid = 1'b0;
    logic          pkt_hs = 1'b0;
    logic [LW-1:0] pkt_len = '0;
    logic          pkt_ready;
    logic [CW-1:0] t_prepare = 8'd3, t_zero = 8'd5, t_pre = 8'd4, t_post = 8'd6, t_trail = 8'd3;
    logic [1:0]    clk_line;
    logic          clk_ready, clk_stop, init_done;
    logic [NL-1:0] data_hs, data_stop;

    always #4 clk = ~clk;

    cls_clk_lane_ctrl #(.NLANES(NL), .CNT_W(CW), .LEN_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .policy_tx_only(policy_tx_only), .lane_mask(lane_mask),
        .pkt_valid(pkt_valid), .pkt_hs(pkt_hs), .pkt_len(pkt_len), .pkt_ready(pkt_ready),
        .t_prepare(t_prepare), .t_zero(t_zero), .t_pre(t_pre), .t_post(t_post), .t_trail(t_trail),
        .clk_line(clk_line), .clk_ready(clk_ready), .clk_stop(clk_stop),
        .data_hs(data_hs), .data_stop(data_stop), .init_done(init_done)
    );

    typedef struct {
        bit            hs;
        int            len;
        logic [NL-1:0] mask;
        bit            cold;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   mon_active = 1'b0;

    function automatic void check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endfunction

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    // ---------------- monitor: scoreboard of lane activity ----------------
    exp_t          cur;
    int            cur_len;
    int            ready_run;
    logic [NL-1:0] act;

    always @(negedge clk) begin
        if (!rst_n) begin
            mon_active = 1'b0;
            ready_run  = 0;
        end else begin
            act = ~data_stop;
            if (!mon_active && act != '0) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected activity", int'(act), 0);
                    cur = '{hs: 1'b0, len: 0, mask: '0, cold: 1'b0};
                end else begin
                    cur = exp_q.pop_front();
                end
                check(act == cur.mask, "R10 latched mask", int'(act), int'(cur.mask));
                check((|data_hs) == cur.hs, "R6 burst kind", int'(|data_hs), int'(cur.hs));
                if (cur.hs) begin
                    check(data_hs == cur.mask, "R4 hs lanes", int'(data_hs), int'(cur.mask));
                    if (cur.cold)
                        check(ready_run == int'(t_pre), "R4 exact lead", ready_run, int'(t_pre));
                    else
                        check(ready_run >= int'(t_pre), "R4 minimum lead", ready_run, int'(t_pre));
                end
                mon_active = 1'b1;
                cur_len    = 1;
            end else if (mon_active && act != '0) begin
                cur_len++;
            end else if (mon_active) begin
                check(cur_len == cur.len, cur.hs ? "R4 burst length" : "R6 lp length", cur_len, cur.len);
                mon_active = 1'b0;
            end
            if (clk_ready) ready_run++;
            else           ready_run = 0;
        end
    end

    // ---------------- monitor: clock lane sequence ----------------
    logic [1:0] prev_line;
    int         lp00_cnt, zero_cnt;
    bit         in_start;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_line = 2'b11;
            lp00_cnt  = 0;
            zero_cnt  = 0;
            in_start  = 1'b0;
        end else begin
            if (prev_line == 2'b11 && clk_line != 2'b11)
                check(clk_line == 2'b01, "R2 leave stop via LP-01", int'(clk_line), 1);
            if (prev_line == 2'b01)
                check(clk_line == 2'b00, "R2 LP-01 one cycle", int'(clk_line), 0);
            if (clk_line == 2'b00) begin
                lp00_cnt++;
            end else if (prev_line == 2'b00) begin
                check(clk_line == 2'b10, "R2 LP-00 then HS", int'(clk_line), 2);
                check(lp00_cnt == int'(t_prepare), "R2 prepare length", lp00_cnt, int'(t_prepare));
                lp00_cnt = 0;
                in_start = 1'b1;
                zero_cnt = 0;
            end
            if (in_start) begin
                if (clk_ready) begin
                    check(zero_cnt == int'(t_zero), "R2 zero length", zero_cnt, int'(t_zero));
                    in_start = 1'b0;
                end else if (clk_line == 2'b10) begin
                    zero_cnt++;
                end
            end
            if (clk_ready && clk_stop)
                check(1'b0, "R7 flags exclusive", 1, 0);
            if (clk_line == 2'b11 && (|data_hs))
                check(1'b0, "R7 LP-11 with burst", int'(data_hs), 0);
            prev_line = clk_line;
        end
    end

    // ---------------- driver ----------------
    task automatic send_pkt(input bit hs, input int len, input bit cold);
        int guard = 0;
        @(negedge clk);
        while (!pkt_ready && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        pkt_valid = 1'b1;
        pkt_hs    = hs;
        pkt_len   = LW'(len);
        exp_q.push_back('{hs: hs, len: (len == 0) ? 1 : len, mask: lane_mask, cold: cold});
        @(negedge clk);
        pkt_valid = 1'b0;
        check(!pkt_ready, "R10 ready drops after accept", int'(pkt_ready), 0);
    endtask

    // mode 1: clock must stay ready, mode 2: clock must stay stopped
    task automatic wait_done(input int mode, input string tag);
        int guard = 0;
        while ((!pkt_ready || mon_active || exp_q.size() != 0) && guard < 2000) begin
            if (mode == 1) check(clk_ready, tag, int'(clk_ready), 1);
            if (mode == 2) check(clk_stop, tag, int'(clk_stop), 1);
            @(negedge clk);
            guard++;
        end
        check(guard < 2000, "R10 packet completes", guard, 0);
    endtask

    task automatic wait_flag(input int which, input string tag);
        int guard = 0;
        while (guard < 200) begin
            if (which == 0 && init_done) break;
            if (which == 1 && clk_ready) break;
            if (which == 2 && clk_stop) break;
            @(negedge clk);
            guard++;
        end
        check(guard < 200, tag, guard, 0);
    endtask

    task automatic measure_stop(input string tag);
        int c = 0;
        int guard = 0;
        while (!pkt_ready && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        while (clk_ready && c < 300) begin
            c++;
            @(negedge clk);
        end
        check(c == int'(t_post), {tag, " R5 post length"}, c, int'(t_post));
        c = 0;
        while (clk_line == 2'b10 && !clk_ready && c < 300) begin
            c++;
            @(negedge clk);
        end
        check(c == int'(t_trail), {tag, " R5 trail length"}, c, int'(t_trail));
        check(clk_stop && clk_line == 2'b11, {tag, " R5 rest at LP-11"}, int'(clk_line), 3);
    endtask

    initial begin
        // R1: state during reset
        repeat (3) @(negedge clk);
        check(clk_line == 2'b11, "R1 clock line", int'(clk_line), 3);
        check(clk_stop && !clk_ready, "R1 clock flags", int'({clk_stop, clk_ready}), 2);
        check(data_stop == 4'b1111 && data_hs == 4'b0000, "R1 lane flags", int'(data_stop), 15);
        check(!init_done && pkt_ready, "R1 init and ready", int'({init_done, pkt_ready}), 1);
        rst_n = 1'b1;

        // R3 / R8: continuous start and init
        wait_flag(0, "R8 init done continuous");
        @(negedge clk);
        check(clk_ready && !clk_stop, "R8 continuous leaves ready", int'({clk_ready, clk_stop}), 2);

        // R6: low-power packet keeps clock running
        send_pkt(1'b0, 5, 1'b0);
        wait_done(1, "R6 clock stays ready in continuous");
        // R4: high-speed packets
        send_pkt(1'b1, 7, 1'b0);
        wait_done(1, "R3 clock ready during hs");
        send_pkt(1'b1, 3, 1'b0);
        send_pkt(1'b0, 0, 1'b0);
        wait_done(1, "R3 clock ready across packets");
        for (int i = 0; i < 20; i++) begin
            check(clk_ready, "R3 continuous never stops", int'(clk_ready), 1);
            @(negedge clk);
        end

        // switch to transmit-only while idle
        policy_tx_only = 1'b1;
        wait_flag(2, "R5 clock stops after policy change");
        check(init_done, "R8 init sticky", int'(init_done), 1);

        // R4/R5: cold high-speed burst in transmit-only
        send_pkt(1'b1, 4, 1'b1);
        measure_stop("tx-only");
        check(exp_q.size() == 0 && !mon_active, "R4 burst consumed", exp_q.size(), 0);

        // R6: low-power packet in transmit-only leaves clock stopped
        send_pkt(1'b0, 6, 1'b0);
        wait_done(2, "R6 clock stays stopped in tx-only");

        // R9: policy change during a packet is deferred
        send_pkt(1'b0, 10, 1'b0);
        @(negedge clk);
        policy_tx_only = 1'b0;
        wait_done(2, "R9 old policy kept during packet");
        wait_flag(1, "R9 new policy applied after packet");

        // second phase: reset in transmit-only, short timers
        @(negedge clk);
        rst_n          = 1'b0;
        policy_tx_only = 1'b1;
        lane_mask      = 4'b0110;
        t_prepare = 8'd1; t_zero = 8'd1; t_pre = 8'd1; t_post = 8'd1; t_trail = 8'd1;
        exp_q.delete();
        repeat (3) @(negedge clk);
        check(clk_stop && !init_done, "R1 second reset", int'({clk_stop, init_done}), 2);
        rst_n = 1'b1;
        wait_flag(0, "R8 init done tx-only");
        @(negedge clk);
        check(clk_stop && !clk_ready, "R8 tx-only leaves stop", int'({clk_stop, clk_ready}), 2);
        send_pkt(1'b1, 2, 1'b1);
        measure_stop("short");
        send_pkt(1'b1, 1, 1'b1);
        measure_stop("single");
        repeat (4) @(negedge clk);
        finish_up();
    end

endmodule